// File: doc/BRIEF.md
# Valid-Ready Write Channel Master

This block turns a single write command into a complete write transaction over three separate flow-controlled channels: an address channel, a data channel and a response channel. A requester presents a start address, a transaction tag, a beat count and up to `MAX_BEATS` data words on a simple command port. The block then offers the address and the first data beat together, without making the data channel wait for the address to be taken.

When the address has been taken and every beat has been accepted, the block opens its response channel. It waits for a response that carries the same tag. That response ends the transaction. The requester then receives a one-cycle completion pulse, the tag and an error flag that follows the returned status code. Only one transaction is in flight at a time. The command port reopens in the same cycle that the completion pulse appears.

Top module: `wr_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cmd_ready` is 1 and `aw_valid`, `w_valid`, `b_ready`, `done` and `done_err` are 0.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. In the next cycle `aw_valid` and `w_valid` are both 1, `aw_addr`/`aw_id` equal the command's address and tag, and `aw_len` equals `cmd_len`. The value of `aw_ready` has no effect on `w_valid`.
- R3: While a valid signal is held and its ready is 0, that valid signal and its payload do not change. A channel moves only on an edge where its valid and its ready are both 1.
- R4: The number of data beats is `cmd_len`+1. Beat i carries `cmd_data[i*DATA_W +: DATA_W]`, and the beats go out in increasing i. `w_last` is 1 only on the final beat, and `w_valid` falls after the final beat is accepted.
- R5: `b_ready` rises in the cycle after the address handshake and the final beat handshake have both taken place, and not earlier. It falls after a matching response is accepted.
- R6: A response accepted while `b_ready` is 1 whose `b_id` differs from `aw_id` is consumed and discarded. It causes no `done`, and `b_ready` stays 1.
- R7: In the cycle after a response with `b_id` equal to `aw_id` is accepted, `done` is 1 for exactly one cycle and `done_id` equals the tag. `done_err` is 1 exactly when `b_resp` is not 2'b00.
- R8: `cmd_ready` is 0 from the cycle after a command is taken until the cycle in which `done` is 1. A `cmd_valid` raised in that window has no effect on the channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_addr | input | ADDR_W | Start address |
| cmd_id | input | ID_W | Transaction tag |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_data | input | MAX_BEATS*DATA_W | Packed beats, beat 0 in the low bits |
| aw_valid | output | 1 | Address valid |
| aw_ready | input | 1 | Address ready |
| aw_addr | output | ADDR_W | Address |
| aw_id | output | ID_W | Tag on the address channel |
| aw_len | output | LEN_W | Beat count minus one |
| w_valid | output | 1 | Data valid |
| w_ready | input | 1 | Data ready |
| w_data | output | DATA_W | Data beat |
| w_last | output | 1 | Final beat marker |
| b_valid | input | 1 | Response valid |
| b_ready | output | 1 | Response ready |
| b_id | input | ID_W | Tag on the response |
| b_resp | input | 2 | Response status, 2'b00 means OK |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion carried a non-OK status |
| done_id | output | ID_W | Tag of the completed transaction |

## Verification
The case hardest to reach from the ports is the one where the data channel runs ahead of the address channel. In that case every beat, including the last, is accepted while the address is still stalled. This shows that data valid never waits on address acceptance, and that `b_ready` waits for both channels. The stimulus holds `aw_ready` low for a set number of cycles while `w_ready` stays high, and it also runs random ready patterns. A second hard case is a response with a foreign tag that arrives while the block is waiting. The bench sends that response directly before the matching one.

// File: rtl/wr_pkg.sv
package wr_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  function automatic logic resp_is_error(input logic [1:0] code);
    return resp_e'(code) != RESP_OKAY;
  endfunction
endpackage

// File: rtl/wr_addr_chan.sv
module wr_addr_chan #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              clear,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              aw_ready,
  output logic              aw_valid,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [ID_W-1:0]   aw_id,
  output logic [LEN_W-1:0]  aw_len,
  output logic              aw_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      aw_valid <= 1'b0;
      aw_done  <= 1'b0;
      aw_addr  <= '0;
      aw_id    <= '0;
      aw_len   <= '0;
    end else begin
      if (start) begin
        aw_valid <= 1'b1;
        aw_done  <= 1'b0;
        aw_addr  <= cmd_addr;
        aw_id    <= cmd_id;
        aw_len   <= cmd_len;
      end else if (aw_valid && aw_ready) begin
        aw_valid <= 1'b0;
        aw_done  <= 1'b1;
      end else if (clear) begin
        aw_done  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wr_data_chan.sv
module wr_data_chan #(
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        clear,
  input  logic [LEN_W-1:0]            cmd_len,
  input  logic [MAX_BEATS*DATA_W-1:0] cmd_data,
  input  logic                        w_ready,
  output logic                        w_valid,
  output logic [DATA_W-1:0]           w_data,
  output logic                        w_last,
  output logic                        w_done
);
  logic [DATA_W-1:0] beat_mem [MAX_BEATS];
  logic [LEN_W-1:0]  idx;
  logic [LEN_W-1:0]  last_idx;
  logic [LEN_W-1:0]  idx_nxt;

  assign idx_nxt = idx + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (start) begin
      for (int i = 0; i < MAX_BEATS; i++) begin
        beat_mem[i] <= cmd_data[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_valid  <= 1'b0;
      w_last   <= 1'b0;
      w_done   <= 1'b0;
      w_data   <= '0;
      idx      <= '0;
      last_idx <= '0;
    end else begin
      if (start) begin
        w_valid  <= 1'b1;
        w_done   <= 1'b0;
        w_data   <= cmd_data[DATA_W-1:0];
        w_last   <= (cmd_len == '0);
        idx      <= '0;
        last_idx <= cmd_len;
      end else if (w_valid && w_ready) begin
        if (w_last) begin
          w_valid <= 1'b0;
          w_last  <= 1'b0;
          w_done  <= 1'b1;
        end else begin
          idx    <= idx_nxt;
          w_data <= beat_mem[idx_nxt];
          w_last <= (idx_nxt == last_idx);
        end
      end else if (clear) begin
        w_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wr_resp_chan.sv
module wr_resp_chan #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            aw_done,
  input  logic            w_done,
  input  logic [ID_W-1:0] exp_id,
  input  logic            b_valid,
  input  logic [ID_W-1:0] b_id,
  input  logic [1:0]      b_resp,
  output logic            b_ready,
  output logic            finish,
  output logic            done,
  output logic            done_err,
  output logic [ID_W-1:0] done_id
);
  assign finish = b_valid && b_ready && (b_id == exp_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_ready  <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
      done_id  <= '0;
    end else begin
      if (finish)                 b_ready <= 1'b0;
      else if (aw_done && w_done) b_ready <= 1'b1;
      done     <= finish;
      done_err <= finish && wr_pkg::resp_is_error(b_resp);
      if (finish) done_id <= b_id;
    end
  end
endmodule

// File: rtl/wr_master.sv
module wr_master #(
  parameter int ADDR_W    = 32,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 4,
  localparam int LEN_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [ID_W-1:0]             cmd_id,
  input  logic [LEN_W-1:0]            cmd_len,
  input  logic [MAX_BEATS*DATA_W-1:0] cmd_data,
  output logic                        aw_valid,
  input  logic                        aw_ready,
  output logic [ADDR_W-1:0]           aw_addr,
  output logic [ID_W-1:0]             aw_id,
  output logic [LEN_W-1:0]            aw_len,
  output logic                        w_valid,
  input  logic                        w_ready,
  output logic [DATA_W-1:0]           w_data,
  output logic                        w_last,
  input  logic                        b_valid,
  output logic                        b_ready,
  input  logic [ID_W-1:0]             b_id,
  input  logic [1:0]                  b_resp,
  output logic                        done,
  output logic                        done_err,
  output logic [ID_W-1:0]             done_id
);
  logic start;
  logic finish;
  logic aw_done;
  logic w_done;

  assign start = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst)         cmd_ready <= 1'b1;
    else if (start)  cmd_ready <= 1'b0;
    else if (finish) cmd_ready <= 1'b1;
  end

  wr_addr_chan #(.ADDR_W(ADDR_W), .ID_W(ID_W), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst(rst), .start(start), .clear(finish),
    .cmd_addr(cmd_addr), .cmd_id(cmd_id), .cmd_len(cmd_len),
    .aw_ready(aw_ready), .aw_valid(aw_valid), .aw_addr(aw_addr),
    .aw_id(aw_id), .aw_len(aw_len), .aw_done(aw_done)
  );

  wr_data_chan #(.DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W)) u_data (
    .clk(clk), .rst(rst), .start(start), .clear(finish),
    .cmd_len(cmd_len), .cmd_data(cmd_data), .w_ready(w_ready),
    .w_valid(w_valid), .w_data(w_data), .w_last(w_last), .w_done(w_done)
  );

  wr_resp_chan #(.ID_W(ID_W)) u_resp (
    .clk(clk), .rst(rst), .aw_done(aw_done), .w_done(w_done),
    .exp_id(aw_id), .b_valid(b_valid), .b_id(b_id), .b_resp(b_resp),
    .b_ready(b_ready), .finish(finish), .done(done),
    .done_err(done_err), .done_id(done_id)
  );
endmodule

// File: rtl/wr_master_chk.sv
module wr_master_chk #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [ID_W-1:0]   aw_id,
  input logic [LEN_W-1:0]  aw_len,
  input logic              w_valid,
  input logic              w_ready,
  input logic [DATA_W-1:0] w_data,
  input logic              w_last,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic              done,
  input logic              done_err
);
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_id) && $stable(aw_len)); // R3
  AST_W_HOLD: assert property (@(posedge clk) disable iff (rst)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_last)); // R3
  AST_DATA_UNGATED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> aw_valid && w_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !aw_valid && !w_valid && !b_ready); // R8
  AST_BREADY_LATE: assert property (@(posedge clk) disable iff (rst)
    b_ready |-> !aw_valid && !w_valid); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(b_valid && b_ready && (b_id == aw_id))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    done_err |-> done); // R7
  AST_FOREIGN_TAG: assert property (@(posedge clk) disable iff (rst)
    b_valid && b_ready && (b_id != aw_id) |=> !done && b_ready); // R6
endmodule

bind wr_master wr_master_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
  .aw_id(aw_id), .aw_len(aw_len), .w_valid(w_valid), .w_ready(w_ready),
  .w_data(w_data), .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready),
  .b_id(b_id), .done(done), .done_err(done_err)
);

// File: tb/wr_master_tb.sv
module wr_master_tb;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int DW = 32;
  localparam int MB = 4;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [IW-1:0] cmd_id = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [MB*DW-1:0] cmd_data = '0;
  logic aw_valid, aw_ready = 1'b0;
  logic [AW-1:0] aw_addr;
  logic [IW-1:0] aw_id;
  logic [LW-1:0] aw_len;
  logic w_valid, w_ready = 1'b0, w_last;
  logic [DW-1:0] w_data;
  logic b_valid = 1'b0, b_ready;
  logic [IW-1:0] b_id = '0;
  logic [1:0] b_resp = '0;
  logic done, done_err;
  logic [IW-1:0] done_id;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wr_master #(.ADDR_W(AW), .ID_W(IW), .DATA_W(DW), .MAX_BEATS(MB)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_id(cmd_id), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id),
    .aw_len(aw_len), .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
    .b_resp(b_resp), .done(done), .done_err(done_err), .done_id(done_id)
  );

  function automatic logic [DW-1:0] exp_beat(input logic [MB*DW-1:0] d, input int i);
    return d[i*DW +: DW];
  endfunction

  function automatic logic exp_err(input logic [1:0] code);
    return code != 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input logic [IW-1:0] id, input int nb,
                         input logic [MB*DW-1:0] d, input logic [1:0] rs, input bit bad_id,
                         input int aw_stall, input int pct);
    int idx = 0;
    bit aw_acc = 0, w_all = 0, prev_both = 0, aw_hs = 0, w_hs = 0;
    chk(cmd_ready === 1'b1, "R8 cmd_ready idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_addr = a; cmd_id = id; cmd_len = LW'(nb - 1); cmd_data = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk(aw_valid && w_valid, "R2 both valids", {aw_valid, w_valid}, 2'b11);
    chk(aw_addr == a, "R2 aw_addr", aw_addr, a);
    chk(aw_id == id && aw_len == LW'(nb - 1), "R2 aw_id/aw_len", {aw_id, aw_len}, {id, LW'(nb - 1)});
    for (int t = 0; t < 400; t++) begin
      if (aw_hs) aw_acc = 1;
      if (w_hs) begin
        if (idx == nb - 1) w_all = 1;
        else idx++;
      end
      chk(b_ready === prev_both, "R5 b_ready timing", b_ready, prev_both);
      if (b_ready) break;
      chk(cmd_ready === 1'b0, "R8 busy", cmd_ready, 0);
      chk(aw_valid === !aw_acc, "R3 aw_valid", aw_valid, !aw_acc);
      if (!aw_acc) chk(aw_addr == a && aw_id == id, "R3 aw payload", aw_addr, a);
      chk(w_valid === !w_all, "R4 w_valid", w_valid, !w_all);
      if (!w_all) begin
        chk(w_data == exp_beat(d, idx), "R4 w_data", w_data, exp_beat(d, idx));
        chk(w_last === (idx == nb - 1), "R4 w_last", w_last, idx == nb - 1);
      end
      prev_both = aw_acc && w_all;
      aw_ready = (t >= aw_stall) && (($urandom % 100) < pct);
      w_ready  = ($urandom % 100) < pct;
      cmd_valid = $urandom % 2;
      cmd_addr = $urandom;
      aw_hs = aw_valid && aw_ready;
      w_hs = w_valid && w_ready;
      @(posedge clk); @(negedge clk);
    end
    aw_ready = 1'b0; w_ready = 1'b0; cmd_valid = 1'b0;
    chk(b_ready === 1'b1, "R5 b_ready reached", b_ready, 1);
    if (bad_id) begin
      b_valid = 1'b1; b_id = id ^ IW'(1); b_resp = 2'b00;
      @(posedge clk); @(negedge clk);
      chk(done === 1'b0, "R6 foreign tag no done", done, 0);
      chk(b_ready === 1'b1, "R6 b_ready held", b_ready, 1);
    end
    b_valid = 1'b1; b_id = id; b_resp = rs;
    @(posedge clk); @(negedge clk);
    b_valid = 1'b0;
    chk(done === 1'b1, "R7 done", done, 1);
    chk(done_err === exp_err(rs), "R7 done_err", done_err, exp_err(rs));
    chk(done_id == id, "R7 done_id", done_id, id);
    chk(cmd_ready === 1'b1, "R8 reopen", cmd_ready, 1);
    chk(b_ready === 1'b0, "R5 b_ready drop", b_ready, 0);
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R7 single pulse", done, 0);
  endtask

  function automatic logic [MB*DW-1:0] rand_data();
    logic [MB*DW-1:0] v;
    for (int i = 0; i < MB; i++) v[i*DW +: DW] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready === 1'b1 && !aw_valid && !w_valid, "R1 reset outputs", {cmd_ready, aw_valid, w_valid}, 3'b100);
    chk(!b_ready && !done && !done_err, "R1 reset response", {b_ready, done, done_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && !aw_valid && !w_valid && !done, "R1 after reset", cmd_ready, 1);
    run_txn(32'h1000, 4'h3, 1, rand_data(), 2'b00, 0, 0, 100);
    run_txn(32'h2040, 4'h7, MB, rand_data(), 2'b00, 0, 10, 100);
    run_txn(32'h30c0, 4'h1, 3, rand_data(), 2'b10, 0, 0, 50);
    run_txn(32'h4000, 4'h9, 2, rand_data(), 2'b00, 1, 2, 70);
    run_txn(32'h5008, 4'hf, MB, rand_data(), 2'b11, 1, 0, 40);
    for (int n = 0; n < 40; n++) begin
      run_txn($urandom, IW'($urandom), 1 + int'($urandom % MB), rand_data(),
               2'($urandom), bit'($urandom % 2), int'($urandom % 6), 30 + int'($urandom % 71));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule